// File: doc/BRIEF.md
# Clipped-Closeness Prototype Scorer

The block measures how close one query vector is to each entry of a bank of stored prototype vectors. Both are cut into 20 unsigned 6-bit fields. For each field pair the block adds a closeness term to a running score. The term is eight minus the absolute difference between the two fields, and it never falls below zero. A prototype that matches exactly scores 160. A prototype whose every field differs by eight or more scores 0.

A single start pulse captures the query, clears the histogram and begins a sweep over every prototype, taking them in index order. The block reads each prototype through a read port with one cycle of latency. The next read is issued while the current prototype is still being scored, so the sweep never stalls. Each prototype costs 20 field cycles plus one write cycle. In the write cycle the final score goes to an external score memory at the prototype's index, and the histogram bin for that score is incremented. A one-cycle done pulse follows the last histogram update. The histogram can then be read through a combinational read port, ready for a later threshold or winner search.

Top module: `proto_scorer`

## Requirements
- R1: Field k of a vector occupies bits [6k+5:6k], for k from 0 to 19. Query field k is compared only with prototype field k.
- R2: The score of a prototype is the sum over all fields of max(0, 8 - |query field - prototype field|), so it lies between 0 and 160.
- R3: During a sweep, each prototype index 0..NUM_PROTO-1 is written exactly once to the score port, in ascending order. Each write lasts one cycle, with score_we_o high, score_addr_o equal to the index and score_data_o equal to the score.
- R4: After a sweep, reading histogram bin b (0..160) on hist_addr_i returns the number of prototypes whose score equals b. The read is combinational.
- R5: A start clears every histogram bin, so the counts after a sweep reflect only that sweep.
- R6: Successive score writes are exactly 21 cycles apart. done_o is high in the 21*NUM_PROTO+3rd cycle counted from the cycle in which start_i was driven.
- R7: done_o is a single-cycle pulse. A start_i pulse while a sweep is running has no effect: the sweep timing and the results are unchanged.
- R8: The query is captured in the cycle start_i is accepted. Later changes on query_i do not affect the running sweep.
- R9: Each prototype index is read exactly once per sweep with proto_rd_en_o high. proto_data_i is taken one cycle after the request.
- R10: After reset, done_o, score_we_o and proto_rd_en_o are low and every histogram bin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep (ignored while one is running) |
| query_i | input | 120 | Query vector, 20 fields of 6 bits |
| proto_rd_en_o | output | 1 | Prototype read request |
| proto_addr_o | output | 13 | Prototype index to read |
| proto_data_i | input | 120 | Prototype data, valid the cycle after the request |
| score_we_o | output | 1 | Score write strobe |
| score_addr_o | output | 13 | Score write index |
| score_data_o | output | 8 | Score value 0..160 |
| hist_addr_i | input | 8 | Histogram bin to read |
| hist_data_o | output | 14 | Count held in the selected bin |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench places directed prototypes at the clipping edges next to random ones. These include an exact match (160), a difference of 7 per field (1 each), a difference of exactly 8 (0), the extremes 0 against 63, and a field ramp that catches swapped or misaligned fields. A wrong clip boundary or a wrong absolute difference shows up as a wrong score at a known index. An off-by-one in the prefetch shows up as scores computed against the neighbouring prototype. A second sweep with a different query checks that the histogram is cleared, since stale counts would add to the new bins. The same sweep pulses start_i and changes query_i mid-run. A design that restarts or reads the live query would break the done timing or the scores.

// File: rtl/scorer_pkg.sv
package scorer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_LOAD,
    ST_FIELD,
    ST_WRITE,
    ST_DONE
  } scan_state_e;
endpackage

// File: rtl/field_closeness.sv
module field_closeness #(
  parameter  int FIELD_W = 6,
  parameter  int CLIP    = 8,
  localparam int TERM_W  = $clog2(CLIP + 1)
) (
  input  logic [FIELD_W-1:0] a_i,
  input  logic [FIELD_W-1:0] b_i,
  output logic [TERM_W-1:0]  term_o
);
  logic [FIELD_W-1:0] diff;

  always_comb begin
    diff = (a_i > b_i) ? (a_i - b_i) : (b_i - a_i);
    if (int'(diff) >= CLIP) term_o = '0;
    else                    term_o = TERM_W'(CLIP - int'(diff));
  end
endmodule

// File: rtl/score_hist.sv
module score_hist #(
  parameter int BINS  = 161,
  parameter int BIN_W = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [BIN_W-1:0] bin_i,
  input  logic [BIN_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o
);
  logic [CNT_W-1:0] cnt [BINS];

  for (genvar g = 0; g < BINS; g++) begin : g_bin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                cnt[g] <= '0;
      else if (clear_i)                           cnt[g] <= '0;
      else if (inc_i && (int'(bin_i) == g))       cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < BINS; b++)
      if (int'(rd_addr_i) == b) rd_data_o = cnt[b];
  end

  a_r4_bin_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (int'(bin_i) < BINS));
  a_r5_clear_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt[0] == '0));
endmodule

// File: rtl/scorer_ctrl.sv
module scorer_ctrl
  import scorer_pkg::*;
#(
  parameter  int NUM_PROTO = 8192,
  parameter  int FIELDS    = 20,
  localparam int IDX_W     = (NUM_PROTO > 1) ? $clog2(NUM_PROTO) : 1,
  localparam int FLD_W     = (FIELDS > 1) ? $clog2(FIELDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             capture_o,
  output logic             load_o,
  output logic             field_en_o,
  output logic             write_o,
  output logic [FLD_W-1:0] fld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PROTO - 1);
  localparam logic [FLD_W-1:0] LAST_FLD = FLD_W'(FIELDS - 1);

  scan_state_e      state_q;
  logic [FLD_W-1:0] fld_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fld_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PRIME;
          idx_q   <= '0;
        end
        ST_PRIME: state_q <= ST_LOAD;
        ST_LOAD: begin
          state_q <= ST_FIELD;
          fld_q   <= '0;
        end
        ST_FIELD: begin
          if (fld_q == LAST_FLD) state_q <= ST_WRITE;
          else                   fld_q   <= fld_q + FLD_W'(1);
        end
        ST_WRITE: begin
          fld_q <= '0;
          if (idx_q == LAST_IDX) state_q <= ST_DONE;
          else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_FIELD;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign capture_o  = (state_q == ST_IDLE) && start_i;
  // proto_q loads once at start-up, then in every write cycle (prefetched data)
  assign load_o     = (state_q == ST_LOAD) || (state_q == ST_WRITE);
  assign field_en_o = (state_q == ST_FIELD);
  assign write_o    = (state_q == ST_WRITE);
  assign done_o     = (state_q == ST_DONE);
  assign fld_o      = fld_q;
  assign idx_o      = idx_q;

  always_comb begin
    rd_en_o   = 1'b0;
    rd_addr_o = '0;
    if (state_q == ST_PRIME) begin
      rd_en_o = 1'b1;
    end else if ((state_q == ST_FIELD) && (fld_q == LAST_FLD) && (idx_q != LAST_IDX)) begin
      rd_en_o   = 1'b1;
      rd_addr_o = idx_q + IDX_W'(1);
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |=> !write_o);
  a_r9_prefetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_o && idx_q != LAST_IDX) |-> $past(rd_en_o));
  a_r6_field_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |-> $past(field_en_o));
endmodule

// File: rtl/proto_scorer.sv
module proto_scorer
  import scorer_pkg::*;
#(
  parameter  int NUM_PROTO = 8192,
  parameter  int FIELDS    = 20,
  parameter  int FIELD_W   = 6,
  parameter  int CLIP      = 8,
  localparam int VEC_W     = FIELDS * FIELD_W,
  localparam int MAX_SCORE = FIELDS * CLIP,
  localparam int SCORE_W   = $clog2(MAX_SCORE + 1),
  localparam int IDX_W     = (NUM_PROTO > 1) ? $clog2(NUM_PROTO) : 1,
  localparam int HIST_W    = $clog2(NUM_PROTO + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [VEC_W-1:0]   query_i,
  output logic               proto_rd_en_o,
  output logic [IDX_W-1:0]   proto_addr_o,
  input  logic [VEC_W-1:0]   proto_data_i,
  output logic               score_we_o,
  output logic [IDX_W-1:0]   score_addr_o,
  output logic [SCORE_W-1:0] score_data_o,
  input  logic [SCORE_W-1:0] hist_addr_i,
  output logic [HIST_W-1:0]  hist_data_o,
  output logic               done_o
);
  localparam int TERM_W = $clog2(CLIP + 1);
  localparam int FLD_W  = (FIELDS > 1) ? $clog2(FIELDS) : 1;

  logic               capture, load, field_en, write;
  logic [FLD_W-1:0]   fld;
  logic [IDX_W-1:0]   idx;
  logic [VEC_W-1:0]   query_q, proto_q;
  logic [FIELD_W-1:0] q_field, p_field;
  logic [TERM_W-1:0]  term;
  logic [SCORE_W-1:0] acc_q;

  scorer_ctrl #(.NUM_PROTO(NUM_PROTO), .FIELDS(FIELDS)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .capture_o (capture),
    .load_o    (load),
    .field_en_o(field_en),
    .write_o   (write),
    .fld_o     (fld),
    .idx_o     (idx),
    .rd_en_o   (proto_rd_en_o),
    .rd_addr_o (proto_addr_o),
    .done_o    (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      query_q <= '0;
      proto_q <= '0;
    end else begin
      if (capture) query_q <= query_i;
      if (load)    proto_q <= proto_data_i;
    end
  end

  assign q_field = query_q[int'(fld)*FIELD_W +: FIELD_W];
  assign p_field = proto_q[int'(fld)*FIELD_W +: FIELD_W];

  field_closeness #(.FIELD_W(FIELD_W), .CLIP(CLIP)) u_close (
    .a_i(q_field), .b_i(p_field), .term_o(term)
  );

  // accumulator clears in the write cycle, ready for the next prototype
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (capture || write)  acc_q <= '0;
    else if (field_en)          acc_q <= acc_q + SCORE_W'(term);
  end

  assign score_we_o   = write;
  assign score_addr_o = idx;
  assign score_data_o = acc_q;

  score_hist #(.BINS(MAX_SCORE + 1), .BIN_W(SCORE_W), .CNT_W(HIST_W)) u_hist (
    .clk_i, .rst_ni,
    .clear_i  (capture),
    .inc_i    (write),
    .bin_i    (acc_q),
    .rd_addr_i(hist_addr_i),
    .rd_data_o(hist_data_o)
  );

  logic             seen_q;
  logic [IDX_W-1:0] last_addr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      last_addr_q <= '0;
    end else if (capture) begin
      seen_q <= 1'b0;
    end else if (score_we_o) begin
      seen_q      <= 1'b1;
      last_addr_q <= score_addr_o;
    end
  end

  a_r2_score_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_we_o |-> (int'(score_data_o) <= MAX_SCORE));
  a_r2_term_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_en |-> (int'(term) <= CLIP));
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score_we_o && seen_q) |-> (score_addr_o == last_addr_q + IDX_W'(1)));
  a_r3_first_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score_we_o && !seen_q) |-> (score_addr_o == '0));
endmodule

// File: tb/sim_proto_scorer.sv
module sim_proto_scorer;
  localparam int N       = 64;
  localparam int FIELDS  = 20;
  localparam int FW      = 6;
  localparam int VW      = FIELDS * FW;
  localparam int BINS    = 161;
  localparam int IW      = $clog2(N);
  localparam int HW      = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [VW-1:0] query = '0;
  logic          rd_en;
  logic [IW-1:0] rd_addr;
  logic [VW-1:0] rd_data = '0;
  logic          s_we;
  logic [IW-1:0] s_addr;
  logic [7:0]    s_data;
  logic [7:0]    h_addr = '0;
  logic [HW-1:0] h_data;
  logic          done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  logic [VW-1:0] mem [N];
  int            got_score [N];
  int            wr_cnt [N];
  int            rd_cnt [N];
  int            last_wr_cyc;
  bit            wr_seen;

  always #10 clk = ~clk;

  proto_scorer #(.NUM_PROTO(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .query_i(query),
    .proto_rd_en_o(rd_en), .proto_addr_o(rd_addr), .proto_data_i(rd_data),
    .score_we_o(s_we), .score_addr_o(s_addr), .score_data_o(s_data),
    .hist_addr_i(h_addr), .hist_data_o(h_data), .done_o(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_en) rd_cnt[rd_addr]++;
    if (s_we) begin
      got_score[s_addr] = int'(s_data);
      wr_cnt[s_addr]++;
      if (wr_seen) check(cyc - last_wr_cyc == 21, "R6 write spacing", cyc - last_wr_cyc, 21);
      wr_seen = 1;
      last_wr_cyc = cyc;
    end
  end

  function automatic int exp_score(input logic [VW-1:0] q, input logic [VW-1:0] p);
    int s = 0;
    for (int k = 0; k < FIELDS; k++) begin
      int a = int'(q[k*FW +: FW]);
      int b = int'(p[k*FW +: FW]);
      int d = (a > b) ? a - b : b - a;
      s += (d >= 8) ? 0 : 8 - d;
    end
    return s;
  endfunction

  function automatic logic [VW-1:0] splat(input int v);
    logic [VW-1:0] r;
    for (int k = 0; k < FIELDS; k++) r[k*FW +: FW] = FW'(v);
    return r;
  endfunction

  function automatic logic [VW-1:0] near(input logic [VW-1:0] q);
    logic [VW-1:0] r;
    for (int k = 0; k < FIELDS; k++) begin
      int v = int'(q[k*FW +: FW]) + int'($urandom % 21) - 10;
      if (v < 0) v = 0;
      if (v > 63) v = 63;
      r[k*FW +: FW] = FW'(v);
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] r;
    for (int k = 0; k < FIELDS; k++) r[k*FW +: FW] = FW'($urandom);
    return r;
  endfunction

  task automatic sweep(input logic [VW-1:0] q, input bit disturb);
    int c0;
    int hist [BINS];
    for (int i = 0; i < N; i++) begin wr_cnt[i] = 0; rd_cnt[i] = 0; got_score[i] = -1; end
    for (int b = 0; b < BINS; b++) hist[b] = 0;
    wr_seen = 0;
    @(negedge clk);
    query = q; start = 1'b1; c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (100) @(negedge clk);
      query = ~q; start = 1'b1;        // R7 / R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(cyc - c0 == 21 * N + 3, "R6 done timing", cyc - c0, 21 * N + 3);
    @(negedge clk);
    check(done == 1'b0, "R7 done pulse width", int'(done), 0);
    for (int i = 0; i < N; i++) begin
      int e = exp_score(q, mem[i]);
      hist[e]++;
      check(got_score[i] == e, $sformatf("R2 R8 score idx %0d", i), got_score[i], e);
      check(wr_cnt[i] == 1, $sformatf("R3 write count idx %0d", i), wr_cnt[i], 1);
      check(rd_cnt[i] == 1, $sformatf("R9 read count idx %0d", i), rd_cnt[i], 1);
    end
    for (int b = 0; b < BINS; b++) begin
      h_addr = 8'(b);
      #1;
      check(int'(h_data) == hist[b], $sformatf("R4 R5 hist bin %0d", b), int'(h_data), hist[b]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] q;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 1'b0, "R10 done at reset", int'(done), 0);
    check(s_we == 1'b0, "R10 score_we at reset", int'(s_we), 0);
    check(rd_en == 1'b0, "R10 rd_en at reset", int'(rd_en), 0);
    for (int b = 0; b < BINS; b += 40) begin
      h_addr = 8'(b); #1;
      check(h_data == '0, "R10 hist at reset", int'(h_data), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // sweep 1: directed edges (R1, R2) plus near-random
    q = splat(0);
    mem[0] = splat(0);      // 160
    mem[1] = splat(63);     // 0
    mem[2] = splat(7);      // 20
    mem[3] = splat(8);      // 0
    for (int k = 0; k < FIELDS; k++) mem[4][k*FW +: FW] = FW'(k);  // R1 ramp: 36
    mem[5] = splat(1);      // 140
    for (int i = 6; i < N; i++) mem[i] = near(q);
    check(exp_score(q, mem[4]) == 36, "R1 ramp reference", exp_score(q, mem[4]), 36);
    sweep(q, 1'b0);

    // sweep 2: random query, mid-run start and query change (R5, R7, R8)
    q = rand_vec();
    mem[0] = q;
    mem[1] = ~q;
    for (int i = 2; i < N; i++) mem[i] = (i % 4 == 0) ? rand_vec() : near(q);
    sweep(q, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule